// File: doc/BRIEF.md
# Audio Clock Generator

This block derives three audio clocks from one fast clock: a master clock, a bit clock and a frame (left/right) clock. Two 6-bit ratio fields set the rates. The divider field `cfg_div` sets the master clock period. The ratio field `cfg_fs` sets the bit clock and frame clock periods. A drive bit chooses whether the master clock appears on its pin or stays low.

The design clock `clk` runs at twice the rate of the generic audio clock. The rates then follow these relations, with `DIV` and `FS` being the field values:

- master clock = generic / (DIV+1)
- frame rate = generic / (32·(FS+1))
- master-clock-to-frame ratio = 32·(FS+1)/(DIV+1)

Two examples: DIV=7 with FS=63 gives a 256·fs master clock, and DIV=0 with FS=47 gives a 1536·fs master clock. The bit clock runs at 64 times the frame rate.

The generator runs only in master mode. A one-cycle `clk_on` strobe starts it and takes a copy of the configuration. A one-cycle `clk_off` strobe stops it. After `clk_off`, each output finishes the period it is in and then holds low, so no output ever shows a shortened pulse. All outputs are registers. This block has no data stream: every pin is a plain level or a one-cycle strobe, and there is no back-pressure.

Top module: `audio_clk_gen`

## Requirements
- R1: After reset, `mck_o`, `bck_o`, `lrck_o` and `busy_o` are all low.
- R2: If `clk_on` is high for one cycle while the block is idle, `cfg_master`=1 and `clk_off`=0, then `busy_o` rises after that edge. One cycle later, `mck_o` and `bck_o` go high and `lrck_o` is low.
- R3: While running, `mck_o` has a period of 2·(DIV+1) clk cycles. It is high for the first DIV+1 cycles of each period and low for the rest, which is exactly 50 % duty.
- R4: If the drive bit was 0 at start, `mck_o` stays low for the whole run, while `bck_o` and `lrck_o` still run.
- R5: For FS ≥ 1, `bck_o` has a period of FS+1 clk cycles. It is high for the first ceil((FS+1)/2) cycles of each period.
- R6: `lrck_o` is low for 32 bit-clock periods and then high for 32. Each change of `lrck_o` falls in the same cycle as a rising edge of `bck_o`.
- R7: `clk_on` is ignored while `cfg_master`=0.
- R8: The ratio fields and the drive bit are copied at start. Changing them while running has no effect until the next start.
- R9: `clk_on` is ignored while `busy_o` is high.
- R10: After `clk_off`, the master clock stops low at the end of its current period. The bit and frame clocks stop low at the end of the current frame. `busy_o` falls once both have stopped.
- R11: If `clk_off` arrives at the edge that ends a master clock period, the master clock stops at that boundary and does not run another period.
- R12: `clk_off` while idle has no effect. `clk_on` and `clk_off` together while idle start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Design clock, twice the generic audio clock rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_master | input | 1 | 1 = master mode (clocks may be generated), 0 = slave |
| cfg_drive_mck | input | 1 | 1 = drive the master clock pin, 0 = hold it low |
| cfg_div | input | 6 | Master clock divider field (DIV) |
| cfg_fs | input | 6 | Frame ratio field (FS) |
| clk_on | input | 1 | One-cycle start strobe |
| clk_off | input | 1 | One-cycle stop strobe |
| mck_o | output | 1 | Master clock |
| bck_o | output | 1 | Bit clock |
| lrck_o | output | 1 | Frame clock |
| busy_o | output | 1 | High while any generator is running |

## Verification
The collision of interest is a stop strobe landing on the edge that ends a master-clock period. In that case the stop request and the period wrap are handled in the same cycle.

The bench reads the phase of its own reference model and raises `clk_off` exactly at that edge. It then requires `mck_o` to stay low for a full period afterwards; a design that only registers the stop request would run one more period. Every cycle, the bench also compares all four outputs against a behavioural model driven by the phase counter. This covers the frame generator as it drains to the end of its frame.

// File: rtl/audio_clk_pkg.sv
package audio_clk_pkg;
  // default field widths of the ratio settings
  localparam int unsigned AC_DIV_W = 6;
  localparam int unsigned AC_FS_W = 6;
  // bit clock periods per half frame
  localparam int unsigned AC_HALF_SLOTS = 32;
endpackage

// File: rtl/audio_clk_ctrl.sv
module audio_clk_ctrl #(
  parameter int unsigned DIV_W = audio_clk_pkg::AC_DIV_W,
  parameter int unsigned FS_W  = audio_clk_pkg::AC_FS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_master,
  input  logic             cfg_drive,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [FS_W-1:0]  cfg_fs,
  input  logic             clk_on,
  input  logic             clk_off,
  input  logic             running,
  output logic             start,
  output logic             stop_now,
  output logic [DIV_W-1:0] div_q,
  output logic [FS_W-1:0]  fs_q,
  output logic             drive_q
);
  logic stop_q;

  // a stop strobe wins over a start strobe in the same cycle
  assign start    = !running && clk_on && !clk_off && cfg_master;
  assign stop_now = running && (stop_q || clk_off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q  <= 1'b0;
      div_q   <= '0;
      fs_q    <= '0;
      drive_q <= 1'b0;
    end else if (start) begin
      stop_q  <= 1'b0;
      div_q   <= cfg_div;
      fs_q    <= cfg_fs;
      drive_q <= cfg_drive;
    end else begin
      stop_q  <= stop_now;
    end
  end

  // R7
  slave_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !cfg_master) |=> !running);
  // R12
  idle_off_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && clk_off) |=> !running);
  // R9
  busy_on_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && clk_on) |=> ($stable(div_q) && $stable(fs_q) && $stable(drive_q)));
endmodule

// File: rtl/audio_clk_mck_div.sv
module audio_clk_mck_div #(
  parameter int unsigned DIV_W = audio_clk_pkg::AC_DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop_now,
  input  logic [DIV_W-1:0] div_q,
  input  logic             drive_q,
  output logic             act,
  output logic             mck_o
);
  localparam int unsigned CW = DIV_W + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] half;
  logic          last;

  assign half = {1'b0, div_q} + CW'(1);
  assign last = (cnt == {div_q, 1'b1});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act   <= 1'b0;
      cnt   <= '0;
      mck_o <= 1'b0;
    end else begin
      mck_o <= act && drive_q && (cnt < half);
      if (start) begin
        act <= 1'b1;
        cnt <= '0;
      end else if (act) begin
        cnt <= last ? '0 : cnt + CW'(1);
        if (last && stop_now) act <= 1'b0;
      end else begin
        cnt <= '0;
      end
    end
  end

  logic [CW:0] hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_run <= '0;
    else        hi_run <= mck_o ? hi_run + (CW+1)'(1) : '0;
  end

  // R3
  mck_high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mck_o |-> (hi_run < {1'b0, half}));
endmodule

// File: rtl/audio_clk_frame_gen.sv
module audio_clk_frame_gen #(
  parameter int unsigned FS_W       = audio_clk_pkg::AC_FS_W,
  parameter int unsigned HALF_SLOTS = audio_clk_pkg::AC_HALF_SLOTS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            stop_now,
  input  logic [FS_W-1:0] fs_q,
  output logic            act,
  output logic            bck_o,
  output logic            lrck_o
);
  localparam int unsigned SLOTS = 2 * HALF_SLOTS;
  localparam int unsigned SW    = $clog2(SLOTS);

  logic [FS_W-1:0] bcnt;
  logic [SW-1:0]   slot;
  logic [FS_W:0]   hi;
  logic            bit_last;
  logic            frame_last;

  assign hi         = ({1'b0, fs_q} + (FS_W+1)'(2)) >> 1;
  assign bit_last   = (bcnt == fs_q);
  assign frame_last = bit_last && (slot == SW'(SLOTS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act    <= 1'b0;
      bcnt   <= '0;
      slot   <= '0;
      bck_o  <= 1'b0;
      lrck_o <= 1'b0;
    end else begin
      bck_o  <= act && ({1'b0, bcnt} < hi);
      lrck_o <= act && (slot >= SW'(HALF_SLOTS));
      if (start) begin
        act  <= 1'b1;
        bcnt <= '0;
        slot <= '0;
      end else if (act) begin
        if (bit_last) begin
          bcnt <= '0;
          slot <= (slot == SW'(SLOTS - 1)) ? '0 : slot + SW'(1);
        end else begin
          bcnt <= bcnt + FS_W'(1);
        end
        if (frame_last && stop_now) act <= 1'b0;
      end else begin
        bcnt <= '0;
        slot <= '0;
      end
    end
  end

  // R6
  lrck_on_bck_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && (lrck_o != $past(lrck_o))) |-> $rose(bck_o));
endmodule

// File: rtl/audio_clk_gen.sv
module audio_clk_gen #(
  parameter int unsigned DIV_W      = audio_clk_pkg::AC_DIV_W,
  parameter int unsigned FS_W       = audio_clk_pkg::AC_FS_W,
  parameter int unsigned HALF_SLOTS = audio_clk_pkg::AC_HALF_SLOTS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_master,
  input  logic             cfg_drive_mck,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [FS_W-1:0]  cfg_fs,
  input  logic             clk_on,
  input  logic             clk_off,
  output logic             mck_o,
  output logic             bck_o,
  output logic             lrck_o,
  output logic             busy_o
);
  logic             start;
  logic             stop_now;
  logic [DIV_W-1:0] div_q;
  logic [FS_W-1:0]  fs_q;
  logic             drive_q;
  logic             mck_act;
  logic             frm_act;

  assign busy_o = mck_act || frm_act;

  audio_clk_ctrl #(.DIV_W(DIV_W), .FS_W(FS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_drive(cfg_drive_mck),
    .cfg_div(cfg_div), .cfg_fs(cfg_fs), .clk_on(clk_on), .clk_off(clk_off),
    .running(busy_o), .start(start), .stop_now(stop_now),
    .div_q(div_q), .fs_q(fs_q), .drive_q(drive_q)
  );

  audio_clk_mck_div #(.DIV_W(DIV_W)) u_mck (
    .clk(clk), .rst_n(rst_n), .start(start), .stop_now(stop_now),
    .div_q(div_q), .drive_q(drive_q), .act(mck_act), .mck_o(mck_o)
  );

  audio_clk_frame_gen #(.FS_W(FS_W), .HALF_SLOTS(HALF_SLOTS)) u_frm (
    .clk(clk), .rst_n(rst_n), .start(start), .stop_now(stop_now),
    .fs_q(fs_q), .act(frm_act), .bck_o(bck_o), .lrck_o(lrck_o)
  );

  // R10
  idle_outputs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !$past(busy_o)) |-> (!mck_o && !bck_o && !lrck_o));
endmodule

// File: tb/audio_clk_gen_bench.sv
`timescale 1ns/1ps
module audio_clk_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_master = 1'b0;
  logic       cfg_drive_mck = 1'b0;
  logic [5:0] cfg_div = '0;
  logic [5:0] cfg_fs = '0;
  logic       clk_on = 1'b0;
  logic       clk_off = 1'b0;
  logic       mck_o, bck_o, lrck_o, busy_o;

  always #10 clk = ~clk;

  audio_clk_gen u_audio_clk_gen (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_drive_mck(cfg_drive_mck),
    .cfg_div(cfg_div), .cfg_fs(cfg_fs), .clk_on(clk_on), .clk_off(clk_off),
    .mck_o(mck_o), .bck_o(bck_o), .lrck_o(lrck_o), .busy_o(busy_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  // behavioural reference: output phase p counts cycles since outputs began
  int m_p = 0, m_M = 1, m_N = 1;
  bit m_drv = 0, m_mlive = 0, m_flive = 0, m_stop = 0, m_busy = 0;
  bit e_mck = 0, e_bck = 0, e_lr = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mlive = 0; m_flive = 0; m_stop = 0; m_busy = 0;
      e_mck = 0; e_bck = 0; e_lr = 0;
    end else if (!m_busy && clk_on && !clk_off && cfg_master) begin
      m_M = int'(cfg_div) + 1; m_N = int'(cfg_fs) + 1; m_drv = cfg_drive_mck;
      m_p = -1; m_mlive = 1; m_flive = 1; m_stop = 0; m_busy = 1;
      e_mck = 0; e_bck = 0; e_lr = 0;
    end else if (m_busy) begin
      bit sn;
      m_p++;
      sn = m_stop || clk_off;
      if (m_mlive) begin
        e_mck = m_drv && ((m_p % (2 * m_M)) < m_M);
        if ((m_p % (2 * m_M)) == 2 * m_M - 1 && sn) m_mlive = 0;
      end else e_mck = 0;
      if (m_flive) begin
        e_bck = (m_p % m_N) < ((m_N + 1) / 2);
        e_lr  = ((m_p / m_N) % 64) >= 32;
        if ((m_p % (64 * m_N)) == 64 * m_N - 1 && sn) m_flive = 0;
      end else begin
        e_bck = 0; e_lr = 0;
      end
      m_stop = sn;
      m_busy = m_mlive || m_flive;
    end else begin
      e_mck = 0; e_bck = 0; e_lr = 0;
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(mck_o == e_mck, "R3 mck_o vs model", mck_o, e_mck);
      chk(bck_o == e_bck, "R5 bck_o vs model", bck_o, e_bck);
      chk(lrck_o == e_lr, "R6 lrck_o vs model", lrck_o, e_lr);
      chk(busy_o == m_busy, "R10 busy_o vs model", busy_o, m_busy);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    finish_up();
  end

  task automatic pulse_on();
    @(negedge clk) clk_on = 1'b1;
    @(negedge clk) clk_on = 1'b0;
  endtask

  task automatic pulse_off();
    @(negedge clk) clk_off = 1'b1;
    @(negedge clk) clk_off = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy_o && n < 6000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // which: 0 = mck_o, 1 = bck_o; measures one high run then the following low run
  function automatic bit pick(input int which);
    return (which == 0) ? mck_o : bck_o;
  endfunction

  task automatic measure(input int which, output int hi, output int lo);
    int g = 0;
    while (pick(which) && g < 5000) begin @(negedge clk); g++; end
    while (!pick(which) && g < 5000) begin @(negedge clk); g++; end
    hi = 0; lo = 0;
    while (pick(which) && g < 5000) begin hi++; @(negedge clk); g++; end
    while (!pick(which) && g < 5000) begin lo++; @(negedge clk); g++; end
  endtask

  initial begin
    int hi, lo, n, mh, bh;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!mck_o && !bck_o && !lrck_o && !busy_o, "R1 reset outputs",
        {mck_o, bck_o, lrck_o, busy_o}, 0);

    // R7 slave mode ignores start
    cfg_div = 6'd7; cfg_fs = 6'd63; cfg_drive_mck = 1'b1;
    pulse_on();
    repeat (3) @(negedge clk);
    chk(!busy_o && !mck_o, "R7 slave start ignored", busy_o, 0);

    // R12 stop while idle, and both strobes together
    cfg_master = 1'b1;
    pulse_off();
    chk(!busy_o, "R12 idle stop ignored", busy_o, 0);
    @(negedge clk) begin clk_on = 1'b1; clk_off = 1'b1; end
    @(negedge clk) begin clk_on = 1'b0; clk_off = 1'b0; end
    repeat (2) @(negedge clk);
    chk(!busy_o && !mck_o && !bck_o, "R12 both strobes no start", busy_o, 0);

    // R2 start timing, DIV=7 FS=63
    pulse_on();
    chk(busy_o && !mck_o, "R2 busy after start edge", {busy_o, mck_o}, 2);
    @(negedge clk);
    chk(mck_o && bck_o && !lrck_o, "R2 first output cycle", {mck_o, bck_o, lrck_o}, 6);

    // R8 config changes while running have no effect
    cfg_div = 6'd1; cfg_fs = 6'd3; cfg_drive_mck = 1'b0;
    measure(0, hi, lo);
    chk(hi == 8, "R8 mck high run after cfg change", hi, 8);
    chk(lo == 8, "R3 mck low run DIV=7", lo, 8);

    // R9 start while busy is ignored
    pulse_on();
    measure(0, hi, lo);
    chk(hi == 8 && busy_o, "R9 start while busy ignored", hi, 8);
    measure(1, hi, lo);
    chk(hi == 32 && lo == 32, "R5 bck runs FS=63", hi, 32);

    // R10 stop drains to frame end
    repeat (50) @(negedge clk);
    pulse_off();
    wait_idle(n);
    chk(n > 0 && n <= 64 * 64 + 1, "R10 stop within one frame", n, 4097);
    mh = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mck_o || bck_o || lrck_o) mh++;
    end
    chk(mh == 0, "R10 outputs quiet after stop", mh, 0);

    // R4 master clock not driven, DIV=0 FS=47
    cfg_div = 6'd0; cfg_fs = 6'd47; cfg_drive_mck = 1'b0;
    pulse_on();
    mh = 0; bh = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (mck_o) mh++;
      if (bck_o) bh++;
    end
    chk(mh == 0, "R4 mck held low", mh, 0);
    chk(bh > 0, "R4 bck still runs", bh, 1);
    pulse_off();
    wait_idle(n);
    chk(!busy_o, "R10 stop FS=47", busy_o, 0);

    // R5 odd bit period and R11 collision, DIV=2 FS=4
    cfg_div = 6'd2; cfg_fs = 6'd4; cfg_drive_mck = 1'b1;
    pulse_on();
    measure(1, hi, lo);
    chk(hi == 3 && lo == 2, "R5 bck odd period high/low", hi * 10 + lo, 32);
    measure(0, hi, lo);
    chk(hi == 3 && lo == 3, "R3 mck DIV=2 duty", hi * 10 + lo, 33);
    while (((m_p + 1) % (2 * m_M)) != 2 * m_M - 1) @(negedge clk);
    clk_off = 1'b1;
    @(negedge clk) clk_off = 1'b0;
    mh = 0;
    for (int i = 0; i < 2 * 3 + 1; i++) begin
      if (mck_o) mh++;
      @(negedge clk);
    end
    chk(mh == 0, "R11 mck stops at colliding boundary", mh, 0);
    wait_idle(n);
    chk(!busy_o, "R10 stop after collision", busy_o, 0);

    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule